// File: doc/BRIEF.md
# Single-Slot Pipeline Queue

This block is a queue with exactly one storage slot that still sustains one transfer per clock. It holds a single data word and a flag that marks the slot as occupied. The producer may push a new word in the same cycle that the consumer pops the held word, because the producer's ready signal is formed combinationally from the consumer's pop request. A stream that pushes and pops every cycle therefore passes through with one cycle of latency and no bubbles.

Inside a cycle the effects are ordered as follows. The consumer first sees the held word. The pop happens next, and the push comes last. A synchronous flush input empties the slot at any time and overrides a push made in the same cycle. It is intended as a pipeline stage between two units where the downstream unit decides each cycle whether it consumes.

Top module: `pipe_fifo1`

## Requirements
- R1: While `rst` is high and after it is released, the slot is empty: `first_valid` = 0, `deq_rdy` = 0 and `enq_rdy` = 1.
- R2: A push (`enq_en` = 1 with `enq_rdy` = 1, `clr` = 0) into an empty slot makes `first_valid` = 1 and `first_data` equal to the pushed word one clock later.
- R3: `deq_rdy` always equals `first_valid`. While the slot is occupied and neither `deq_en` nor `clr` is high, `enq_rdy` is 0, and a push request leaves `first_data` and `first_valid` unchanged.
- R4: While the slot is occupied, `enq_rdy` is 1 in the same cycle that `deq_en` is 1, with no clock edge in between.
- R5: A pop (`deq_en` = 1 while occupied) with no push and no flush leaves the slot empty one clock later.
- R6: A push and a pop in the same cycle keep the slot occupied, and `first_data` becomes the pushed word one clock later.
- R7: `clr` = 1 leaves the slot empty one clock later, whatever the values of `enq_en` and `deq_en` in that cycle.
- R8: `deq_en` while the slot is empty has no effect: the slot stays empty and `enq_rdy` remains 1.
- R9: With a push and a pop in every cycle, the consumer sees every pushed word exactly once, in the order pushed, at one word per clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| enq_en | input | 1 | Push request |
| enq_data | input | DATA_W | Word to push |
| enq_rdy | output | 1 | Push accepted this cycle if requested |
| deq_en | input | 1 | Pop request |
| deq_rdy | output | 1 | A word is available to pop |
| first_data | output | DATA_W | Held word |
| first_valid | output | 1 | Held word is valid |
| clr | input | 1 | Synchronous flush, always accepted |

## Verification
`enq_rdy` depends on the current inputs with zero latency, so the bench reads it a short time after it drives the inputs at a falling edge, before the next rising edge. `first_valid`, `first_data` and `deq_rdy` come from registers and change one rising edge after the push, pop or flush that caused them. The bench therefore compares them at the falling edge that follows that rising edge, before it drives the next inputs. In the streaming test, the word checked at a falling edge is the one pushed one cycle earlier, which shows that the slot adds exactly one cycle of latency.

// File: rtl/pfifo_pkg.sv
package pfifo_pkg;

    // Update chosen for the single slot in a given cycle.
    typedef enum logic [1:0] {
        SLOT_KEEP  = 2'd0,
        SLOT_LOAD  = 2'd1,
        SLOT_DRAIN = 2'd2,
        SLOT_FLUSH = 2'd3
    } slot_op_e;

    // Flush beats load. Load (also when a pop happens in the same cycle) beats drain.
    function automatic slot_op_e pick_op(input logic flush,
                                         input logic load,
                                         input logic drain);
        slot_op_e op;
        if (flush)      op = SLOT_FLUSH;
        else if (load)  op = SLOT_LOAD;
        else if (drain) op = SLOT_DRAIN;
        else            op = SLOT_KEEP;
        return op;
    endfunction

endpackage

// File: rtl/pf_ctrl.sv
module pf_ctrl
    import pfifo_pkg::*;
(
    input  logic     occupied,
    input  logic     enq_en,
    input  logic     deq_en,
    input  logic     clr,
    output logic     enq_rdy,
    output logic     deq_rdy,
    output slot_op_e op
);
    logic pop_fire;
    logic push_fire;

    always_comb begin
        deq_rdy   = occupied;
        pop_fire  = deq_en & occupied;
        // A pop in the same cycle frees the slot before the push lands.
        enq_rdy   = ~occupied | pop_fire;
        push_fire = enq_en & enq_rdy;
        op        = pick_op(clr, push_fire, pop_fire);
    end
endmodule

// File: rtl/pf_slot.sv
module pf_slot
    import pfifo_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  slot_op_e          op,
    input  logic [DATA_W-1:0] din,
    output logic              occupied,
    output logic [DATA_W-1:0] dout
);
    always_ff @(posedge clk) begin
        if (rst) begin
            occupied <= 1'b0;
            dout     <= '0;
        end else begin
            unique case (op)
                SLOT_LOAD: begin
                    occupied <= 1'b1;
                    dout     <= din;
                end
                SLOT_DRAIN, SLOT_FLUSH: occupied <= 1'b0;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/pipe_fifo1.sv
module pipe_fifo1
    import pfifo_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enq_en,
    input  logic [DATA_W-1:0] enq_data,
    output logic              enq_rdy,
    input  logic              deq_en,
    output logic              deq_rdy,
    output logic [DATA_W-1:0] first_data,
    output logic              first_valid,
    input  logic              clr
);
    slot_op_e slot_op;
    logic     occupied;

    pf_ctrl u_ctrl (
        .occupied (occupied),
        .enq_en   (enq_en),
        .deq_en   (deq_en),
        .clr      (clr),
        .enq_rdy  (enq_rdy),
        .deq_rdy  (deq_rdy),
        .op       (slot_op)
    );

    pf_slot #(.DATA_W(DATA_W)) u_slot (
        .clk      (clk),
        .rst      (rst),
        .op       (slot_op),
        .din      (enq_data),
        .occupied (occupied),
        .dout     (first_data)
    );

    assign first_valid = occupied;
endmodule

// File: rtl/pipe_fifo1_chk.sv
module pipe_fifo1_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              enq_en,
    input logic [DATA_W-1:0] enq_data,
    input logic              enq_rdy,
    input logic              deq_en,
    input logic              deq_rdy,
    input logic [DATA_W-1:0] first_data,
    input logic              first_valid,
    input logic              clr
);
    assert_reset_empty_R1: assert property (@(posedge clk)
        rst |=> !first_valid);

    assert_load_R2: assert property (@(posedge clk) disable iff (rst)
        (enq_en && enq_rdy && !clr) |=> (first_valid && first_data == $past(enq_data)));

    assert_rdy_match_R3: assert property (@(posedge clk) disable iff (rst)
        deq_rdy == first_valid);

    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (first_valid && !deq_en && !clr) |=> (first_valid && $stable(first_data)));

    assert_bypass_rdy_R4: assert property (@(posedge clk) disable iff (rst)
        (first_valid && deq_en) |-> enq_rdy);

    assert_drain_R5: assert property (@(posedge clk) disable iff (rst)
        (first_valid && deq_en && !enq_en && !clr) |=> !first_valid);

    assert_flush_R7: assert property (@(posedge clk) disable iff (rst)
        clr |=> !first_valid);

    assert_empty_rdy_R8: assert property (@(posedge clk) disable iff (rst)
        !first_valid |-> enq_rdy);
endmodule

bind pipe_fifo1 pipe_fifo1_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .enq_en      (enq_en),
    .enq_data    (enq_data),
    .enq_rdy     (enq_rdy),
    .deq_en      (deq_en),
    .deq_rdy     (deq_rdy),
    .first_data  (first_data),
    .first_valid (first_valid),
    .clr         (clr)
);

// File: tb/test_pipe_fifo1.sv
`timescale 1ns/1ps
module test_pipe_fifo1;
    localparam int W = 8;
    localparam int NVEC = 11;
    localparam int NSTREAM = 50;

    logic         clk = 1'b0;
    logic         rst;
    logic         enq_en, deq_en, clr;
    logic [W-1:0] enq_data;
    logic         enq_rdy, deq_rdy, first_valid;
    logic [W-1:0] first_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    pipe_fifo1 #(.DATA_W(W)) i_pipe_fifo1 (
        .clk(clk), .rst(rst), .enq_en(enq_en), .enq_data(enq_data),
        .enq_rdy(enq_rdy), .deq_en(deq_en), .deq_rdy(deq_rdy),
        .first_data(first_data), .first_valid(first_valid), .clr(clr)
    );

    // Vector: {clr, enq, deq, data[7:0], exp_rdy, exp_valid_after, exp_data_after[7:0]}
    localparam logic [20:0] VEC [NVEC] = '{
        {1'b0,1'b1,1'b0,8'hA5, 1'b1, 1'b1,8'hA5},  // R2 push into empty
        {1'b0,1'b1,1'b0,8'h3C, 1'b0, 1'b1,8'hA5},  // R3 push while full, ignored
        {1'b0,1'b0,1'b0,8'h00, 1'b0, 1'b1,8'hA5},  // R3 hold
        {1'b0,1'b1,1'b1,8'h3C, 1'b1, 1'b1,8'h3C},  // R6 push+pop
        {1'b0,1'b0,1'b1,8'h00, 1'b1, 1'b0,8'h00},  // R5 pop alone
        {1'b0,1'b0,1'b1,8'h00, 1'b1, 1'b0,8'h00},  // R8 pop while empty
        {1'b0,1'b1,1'b1,8'h77, 1'b1, 1'b1,8'h77},  // R8 push with pop on empty
        {1'b1,1'b0,1'b0,8'h00, 1'b0, 1'b0,8'h00},  // R7 flush
        {1'b1,1'b1,1'b0,8'h11, 1'b1, 1'b0,8'h00},  // R7 flush beats push
        {1'b0,1'b1,1'b0,8'h22, 1'b1, 1'b1,8'h22},  // R2 refill
        {1'b1,1'b1,1'b1,8'h44, 1'b1, 1'b0,8'h00}   // R7 flush with push+pop
    };

    function automatic string vec_tag(input int i);
        case (i)
            0, 9:       return "R2";
            1, 2:       return "R3";
            3:          return "R6";
            4:          return "R5";
            5, 6:       return "R8";
            default:    return "R7";
        endcase
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1; enq_en = 0; deq_en = 0; clr = 0; enq_data = '0;
        repeat (3) @(negedge clk);
        // R1: empty during reset
        check("R1", "first_valid in reset", first_valid, 0);
        check("R1", "deq_rdy in reset", deq_rdy, 0);
        check("R1", "enq_rdy in reset", enq_rdy, 1);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "first_valid after reset", first_valid, 0);

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            logic [20:0] v;
            v = VEC[i];
            clr = v[20]; enq_en = v[19]; deq_en = v[18]; enq_data = v[17:10];
            #2;
            check(vec_tag(i), "enq_rdy same cycle", enq_rdy, v[9]);
            @(negedge clk);
            check(vec_tag(i), "first_valid", first_valid, v[8]);
            check("R3", "deq_rdy matches first_valid", deq_rdy, first_valid);
            if (v[8]) check(vec_tag(i), "first_data", first_data, v[7:0]);
        end
        clr = 0; enq_en = 0; deq_en = 0;

        // R4: full slot, pop request raises enq_rdy combinationally
        enq_en = 1; enq_data = 8'h5A;
        @(negedge clk);
        enq_en = 0;
        #2;
        check("R4", "enq_rdy full, no pop", enq_rdy, 0);
        deq_en = 1;
        #2;
        check("R4", "enq_rdy full, pop same cycle", enq_rdy, 1);
        deq_en = 0;
        #2;
        check("R4", "enq_rdy after pop withdrawn", enq_rdy, 0);

        // R1: reset while occupied empties the slot
        rst = 1;
        @(negedge clk);
        rst = 0;
        check("R1", "first_valid after mid-run reset", first_valid, 0);

        // R9: back-to-back stream
        enq_en = 1; enq_data = 8'd0;
        @(negedge clk);
        for (int i = 0; i < NSTREAM; i++) begin
            check("R9", "stream valid", first_valid, 1);
            check("R9", "stream word", first_data, i[W-1:0]);
            enq_en = 1; deq_en = 1; enq_data = W'(i + 1);
            #2;
            check("R9", "stream enq_rdy", enq_rdy, 1);
            @(negedge clk);
        end
        enq_en = 0; deq_en = 1;
        check("R9", "last word", first_data, NSTREAM);
        @(negedge clk);
        deq_en = 0;
        check("R9", "empty after drain", first_valid, 0);

        finish_run();
    end
endmodule